// File: doc/BRIEF.md
# Serial Converter Output Port Sequencer

This block is the digital back end of a slow converter's serial output port. It runs a conversion timer for a fixed number of system clocks, captures a result word from a parallel input port when the timer expires, and then waits in a sleep phase. An external host reads the word using its own serial clock, qualified by an active-low chip select. The block has no separate ready pin. The host learns whether a result is waiting by pulling chip select low and looking at the data line.

The host's serial clock and chip select are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are detected in the system clock domain. Outgoing data changes only after falling serial clock edges, so the host samples on rising edges. A frame is 32 bits. The first bit is the status flag and the remaining 31 bits are the captured result. The host can cut a frame short by raising chip select. This also restarts the conversion timer, so the host can use it to resynchronise conversions.

Top module: `serialAdcPort`

## Requirements
- R1: While chip select is low and no frame is in progress, `sdoData` is 1 during a conversion and 0 during sleep.
- R2: A conversion lasts `CONV_CYCLES` system clocks from reset release or from a restart. At completion the block captures `resultIn` and enters sleep without further stimulus.
- R3: Sleep lasts until a rising serial clock edge is seen while chip select is low. Serial clock activity while chip select is high neither starts a frame nor shifts the stored word.
- R4: A frame has 32 bits and its bit order is fixed. Bit 31 (first, valid at the first rising edge) is the status value 0. Bits 30 down to 0 follow as `resultIn[30]` down to `resultIn[0]`, each one presented after the preceding falling edge. The last bit is valid at the 32nd rising edge.
- R5: The 32nd falling serial clock edge of a frame starts a new conversion, and `sdoData` returns to 1.
- R6: A rising edge on chip select during a frame aborts the frame at once. It starts a new conversion with a full-length timer, and the next frame carries the value captured at the end of that conversion.
- R7: `sdoOe` is 0 while the synchronized chip select is high (the line is high-impedance) and 1 while it is low.
- R8: During reset the block is in the conversion phase with `sdoOe` at 0 and `sdoData` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Host serial clock, asynchronous |
| csNIn | input | 1 | Host chip select, active low, asynchronous |
| resultIn | input | WORD_W-1 | Parallel conversion result, sampled when a conversion completes |
| sdoData | output | 1 | Serial data / status value |
| sdoOe | output | 1 | Output enable for the serial data line; 0 means high-impedance |

## Verification
The main read path is driven with result words of all zeros, all ones, alternating bits and an irregular value. These separate a stuck or inverted data line, a shift off by one position, and a missing status bit. Directed cases toggle the serial clock while chip select is high during sleep, to show that such activity neither starts a frame nor shifts the word. A frame aborted after five bits shows that the timer restarts and that a fresh result is captured. The time from reset release to sleep is measured to confirm the conversion length.

// File: rtl/adcPortPkg.sv
package adcPortPkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } phaseT;

  typedef struct packed {
    logic load;    // capture parallel result into the shift register
    logic shift;   // advance one bit after a serial clock falling edge
  } strobeT;
endpackage

// File: rtl/adcEdgeSync.sv
module adcEdgeSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else if (g == 0) chain[g] <= asyncIn;
        else chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/adcCtrl.sv
module adcCtrl
  import adcPortPkg::*;
#(
  parameter int CONV_CYCLES = 64,
  parameter int WORD_W      = 32,
  localparam int TIMER_W    = $clog2(CONV_CYCLES + 1),
  localparam int FCNT_W     = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csLow,
  input  logic              csRise,
  output phaseT             phase,
  output strobeT            strobe,
  output logic [FCNT_W-1:0] fallCnt
);
  phaseT              phaseNxt;
  logic [TIMER_W-1:0] timer;
  logic               startConv;

  always_comb begin
    phaseNxt  = phase;
    strobe    = '0;
    startConv = 1'b0;
    case (phase)
      ST_CONV: begin
        if (timer == TIMER_W'(CONV_CYCLES - 1)) begin
          strobe.load = 1'b1;
          phaseNxt    = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (sckRise && csLow) phaseNxt = ST_DOUT;
      end
      ST_DOUT: begin
        if (csRise) begin
          phaseNxt  = ST_CONV;
          startConv = 1'b1;
        end else if (sckFall) begin
          strobe.shift = 1'b1;
          if (fallCnt == FCNT_W'(WORD_W - 1)) begin
            phaseNxt  = ST_CONV;
            startConv = 1'b1;
          end
        end
      end
      default: phaseNxt = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_CONV;
      timer   <= '0;
      fallCnt <= '0;
    end else begin
      phase <= phaseNxt;
      if (phase == ST_CONV && phaseNxt == ST_CONV) timer <= timer + 1'b1;
      else timer <= '0;
      if (startConv) fallCnt <= '0;
      else if (strobe.shift) fallCnt <= fallCnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcDatapath.sv
module adcDatapath
  import adcPortPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  phaseT             phase,
  input  strobeT            strobe,
  input  logic              csLow,
  input  logic [WORD_W-2:0] resultIn,
  output logic              sdoData,
  output logic              sdoOe
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.load) shiftReg <= {1'b0, resultIn};
    else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  assign sdoData = (phase == ST_CONV) ? 1'b1 : shiftReg[WORD_W-1];
  assign sdoOe   = csLow;
endmodule

// File: rtl/serialAdcPort.sv
module serialAdcPort
  import adcPortPkg::*;
#(
  parameter int CONV_CYCLES = 64,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int FCNT_W     = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic [WORD_W-2:0] resultIn,
  output logic              sdoData,
  output logic              sdoOe
);
  logic              sckLevel, sckRise, sckFall;
  logic              csNLevel, csRise, csFall;
  phaseT             phase;
  strobeT            strobe;
  logic [FCNT_W-1:0] fallCnt;

  adcEdgeSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sckSync (
    .clk(clk), .rstN(rstN), .asyncIn(sckIn),
    .level(sckLevel), .rise(sckRise), .fall(sckFall)
  );

  adcEdgeSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_csSync (
    .clk(clk), .rstN(rstN), .asyncIn(csNIn),
    .level(csNLevel), .rise(csRise), .fall(csFall)
  );

  adcCtrl #(.CONV_CYCLES(CONV_CYCLES), .WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csLow(~csNLevel), .csRise(csRise),
    .phase(phase), .strobe(strobe), .fallCnt(fallCnt)
  );

  adcDatapath #(.WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .phase(phase), .strobe(strobe),
    .csLow(~csNLevel), .resultIn(resultIn),
    .sdoData(sdoData), .sdoOe(sdoOe)
  );

  logic unusedBits;
  assign unusedBits = sckLevel ^ csFall;
endmodule

// File: rtl/adcPortChk.sv
module adcPortChk
  import adcPortPkg::*;
#(
  parameter int WORD_W = 32,
  localparam int FCNT_W = $clog2(WORD_W) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              csNIn,
  input logic              sdoData,
  input logic              sdoOe,
  input phaseT             phase,
  input logic [FCNT_W-1:0] fallCnt
);
  // R7
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csNIn && $past(csNIn) && $past(csNIn, 2) && $past(csNIn, 3)) |-> !sdoOe);

  // R1
  busy_flag_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_CONV) |-> sdoData);

  // R1
  ready_flag_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_SLEEP) |-> !sdoData);

  // R3
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_SLEEP) |=> (phase != ST_CONV));

  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_DOUT) |-> (fallCnt < FCNT_W'(WORD_W)));

  // R5
  frame_end_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == ST_DOUT && phase == ST_CONV) |-> (fallCnt == '0));
endmodule

bind serialAdcPort adcPortChk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .csNIn(csNIn), .sdoData(sdoData),
  .sdoOe(sdoOe), .phase(phase), .fallCnt(fallCnt)
);

// File: tb/test_serialAdcPort.sv
`timescale 1ns/1ps
module test_serialAdcPort;
  localparam int N = 40;
  localparam int W = 32;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0;
  logic csNIn = 1'b0;
  logic [W-2:0] resultIn = '0;
  logic sdoData, sdoOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serialAdcPort #(.CONV_CYCLES(N), .WORD_W(W)) i_serialAdcPort (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn),
    .resultIn(resultIn), .sdoData(sdoData), .sdoOe(sdoOe)
  );

  localparam logic [W-2:0] VEC [4] = '{31'h0000_0000, 31'h7FFF_FFFF,
                                       31'h2AAA_AAAA, 31'h1234_5678};

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitSleep(output int cyc);
    cyc = 0;
    while (sdoData !== 1'b0 && cyc < 400) begin
      ticks(1);
      cyc++;
    end
  endtask

  task automatic readBits(input int nBits, output logic [W-1:0] word);
    word = '0;
    for (int i = 0; i < nBits; i++) begin
      sckIn = 1'b1;
      ticks(HALF);
      word = {word[W-2:0], sdoData};
      sckIn = 1'b0;
      ticks(HALF);
    end
  endtask

  initial begin
    int cyc;
    logic [W-1:0] word;
    resultIn = VEC[0];
    ticks(2);
    // R8 reset state
    check(sdoOe == 1'b0, "R8 oe in reset", sdoOe, 0);
    check(sdoData == 1'b1, "R8 busy in reset", sdoData, 1);
    rstN = 1'b1;
    ticks(N - 2);
    // R2 still converting shortly before the end
    check(sdoData == 1'b1 && sdoOe == 1'b1, "R2 busy before end", sdoData, 1);
    ticks(3);
    check(sdoData == 1'b0, "R2 sleep after CONV_CYCLES", sdoData, 0);

    // table walk: R4 frame content, R5 restart
    for (int v = 0; v < 4; v++) begin
      resultIn = VEC[v];
      waitSleep(cyc);
      check(sdoData == 1'b0, "R1 ready flag", sdoData, 0);
      readBits(W, word);
      check(word[W-1] == 1'b0, "R4 status bit", word[W-1], 0);
      check(word == {1'b0, VEC[v]}, "R4 frame word", word, {1'b0, VEC[v]});
      check(sdoData == 1'b1, "R5 busy after 32nd fall", sdoData, 1);
    end

    // R7 high-impedance and status on demand
    csNIn = 1'b1;
    ticks(5);
    check(sdoOe == 1'b0, "R7 hi-z when cs high", sdoOe, 0);
    csNIn = 1'b0;
    ticks(4);
    check(sdoOe == 1'b1, "R7 driven when cs low", sdoOe, 1);
    check(sdoData == 1'b1, "R1 busy visible", sdoData, 1);

    // R3 sck with cs high is ignored in sleep
    resultIn = 31'h5A5A_1234;
    waitSleep(cyc);
    csNIn = 1'b1;
    ticks(4);
    for (int k = 0; k < 3; k++) begin
      sckIn = 1'b1; ticks(HALF);
      sckIn = 1'b0; ticks(HALF);
    end
    csNIn = 1'b0;
    ticks(5);
    check(sdoData == 1'b0, "R3 still asleep", sdoData, 0);
    readBits(W, word);
    check(word == {1'b0, 31'h5A5A_1234}, "R3 word not shifted", word, {1'b0, 31'h5A5A_1234});

    // R6 abort mid-frame
    resultIn = 31'h0F0F_0F0F;
    waitSleep(cyc);
    readBits(5, word);
    csNIn = 1'b1;
    resultIn = 31'h3C3C_5AA5;
    ticks(5);
    csNIn = 1'b0;
    ticks(4);
    check(sdoData == 1'b1, "R6 conversion after abort", sdoData, 1);
    waitSleep(cyc);
    check(cyc >= N - 12 && cyc <= N, "R6 full timer after abort", cyc, N - 9);
    readBits(W, word);
    check(word == {1'b0, 31'h3C3C_5AA5}, "R6 fresh result", word, {1'b0, 31'h3C3C_5AA5});

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule